// File: doc/BRIEF.md
# Single-Step Trace Trap Unit

This block decides, at each instruction commit point, whether the processor must take a trap and which cause it reports. Besides the ordinary synchronous causes (data-type check, arithmetic overflow, memory-data read fault) and a pending asynchronous interrupt, it provides a single-step facility. When a trap handler returns with the trace enable set, the instruction it returns to runs normally. If that instruction commits without any other cause, the next commit point raises a trace trap unconditionally. If the returned-to instruction runs into any ordinary cause or an interrupt, that trap is taken instead and the trace request is discarded, so the handler does not trace itself.

When several causes are present at one commit point, the highest-ranked one is taken and the rest are kept in a pending set. Pending causes join the live requests at the following accepted commits and are taken one per commit in priority order. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake. The trap strobe is registered, and the cause code is held until the next trap return clears it.

Top module: `trace_trap_unit`

## Requirements
- R1: After reset `trap_take` is 0, `trap_cause` is 0, no cause is pending and trace mode is off.
- R2: A trap return with `ret_trace_en`=1 arms trace mode. A trap return with `ret_trace_en`=0 leaves it off, so a run of clean commits after it raises no trap.
- R3: With trace armed, the first accepted commit with no live or pending cause raises no trap.
- R4: The accepted commit after that clean first commit raises a trace trap with cause code 5.
- R5: An ordinary cause or interrupt at the returned-to instruction's commit is taken with its own code, and no trace trap follows at the next commit.
- R6: A memory-data read fault (code 4) on its own at the returned-to commit also cancels the trace trap.
- R7: Cause codes and priority, from highest to lowest: interrupt=1, data type=2, overflow=3, memory data=4, trace=5. Code 0 means no cause.
- R8: Causes that lose at a commit are kept and taken at later accepted commits, one per commit, in priority order. Trace is never kept in this pending set.
- R9: An ordinary cause present at the commit where trace is due pre-empts the trace trap, and the trace request is dropped.
- R10: `trap_cause` keeps its value from a trap strobe until the next trap return, which sets it to 0.
- R11: Requests raised in cycles without `commit` are ignored: nothing is taken and nothing is made pending.
- R12: When `commit` and `ret_strobe` are high in the same cycle, the return wins. The commit and its requests are ignored.
- R13: `trap_take` is a one-cycle pulse in the cycle after the clock edge that samples the accepted commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_strobe | input | 1 | Trap-return sequence completes this cycle |
| ret_trace_en | input | 1 | Trace mode bit written by the trap return |
| commit | input | 1 | An instruction reaches its commit point |
| irq_pending | input | 1 | Asynchronous interrupt waiting |
| req_dtype | input | 1 | Data-type trap request from the current instruction |
| req_ovf | input | 1 | Overflow trap request from the current instruction |
| req_mdata | input | 1 | Memory-data read trap request from the current instruction |
| trap_take | output | 1 | Trap entry strobe |
| trap_cause | output | 3 | Cause code of the last trap taken |

## Verification
Two functions can meet at one commit point: the deferred trace trap and an ordinary trap or interrupt. A second collision is a new request arriving while lower-ranked causes are still pending. The bench provokes both by sweeping all sixteen request combinations, once at the returned-to instruction's commit and once at the commit where trace is due. After each case it drains the pending set with clean commits. Every strobe and code is compared against a priority model computed in the bench, so a lost, repeated or misordered cause is caught, and so is a trace trap that survives a pre-emption.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned SRC_N   = 4;  // interrupt, data type, overflow, memory data
  localparam int unsigned CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE  = 3'd0,
    CZ_IRQ   = 3'd1,
    CZ_DTYPE = 3'd2,
    CZ_OVF   = 3'd3,
    CZ_MDATA = 3'd4,
    CZ_TRACE = 3'd5
  } cause_e;
endpackage

// File: rtl/tt_prio.sv
module tt_prio #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] code
);
  // lower index wins; blocked[i] is set when any lower index requests
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign blocked[g+1] = blocked[g] | req[g];
      assign grant[g]     = req[g] & ~blocked[g];
    end
  endgenerate

  assign any = blocked[N];

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = CW'(i + 1);
    end
  end

  // R7: exactly one grant whenever something requests
  always_comb begin
    a_r7_one_grant: assert (any ? $onehot(grant) : (grant == '0));
  end
endmodule

// File: rtl/tt_pend.sv
module tt_pend #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [N-1:0] merged,
  input  logic [N-1:0] grant,
  output logic [N-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= merged & ~grant;
  end

  // R11: the pending set only changes on an accepted commit
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held));
  // R8: the cause granted at a commit is not also kept
  a_r8_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ((held & $past(grant)) == '0));
endmodule

// File: rtl/tt_seq.sv
module tt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ret,
  input  logic trace_en,
  input  logic commit_ok,
  input  logic ord_hit,
  output logic trace_fire
);
  logic armed;  // returned-to instruction not yet committed
  logic due;    // next commit raises the trace trap

  assign trace_fire = commit_ok & due & ~ord_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      due   <= 1'b0;
    end else if (ret) begin
      armed <= trace_en;
      due   <= 1'b0;
    end else if (commit_ok) begin
      if (ord_hit) begin
        armed <= 1'b0;
        due   <= 1'b0;
      end else begin
        due   <= armed;
        armed <= 1'b0;
      end
    end
  end

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && due));
  // R5 / R9: any ordinary trap clears all trace state
  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && ord_hit) |=> (!armed && !due));
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    (due && commit_ok) |=> !due);
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !trace_en) |=> (!armed && !due));
endmodule

// File: rtl/trace_trap_unit.sv
module trace_trap_unit
  import tt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ret_strobe,
  input  logic                ret_trace_en,
  input  logic                commit,
  input  logic                irq_pending,
  input  logic                req_dtype,
  input  logic                req_ovf,
  input  logic                req_mdata,
  output logic                trap_take,
  output logic [CAUSE_W-1:0]  trap_cause
);
  logic               commit_ok;
  logic [SRC_N-1:0]   live_req;
  logic [SRC_N-1:0]   held;
  logic [SRC_N-1:0]   merged;
  logic [SRC_N-1:0]   grant;
  logic               ord_any;
  logic [CAUSE_W-1:0] ord_code;
  logic               trace_fire;
  logic               take_d;
  logic [CAUSE_W-1:0] next_cause;

  assign commit_ok = commit & ~ret_strobe;               // return wins
  assign live_req  = {req_mdata, req_ovf, req_dtype, irq_pending};
  assign merged    = live_req | held;

  tt_prio #(.N(SRC_N), .CW(CAUSE_W)) u_prio (
    .req   (merged),
    .any   (ord_any),
    .grant (grant),
    .code  (ord_code)
  );

  tt_pend #(.N(SRC_N)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (commit_ok),
    .merged  (merged),
    .grant   (grant),
    .held    (held)
  );

  tt_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret        (ret_strobe),
    .trace_en   (ret_trace_en),
    .commit_ok  (commit_ok),
    .ord_hit    (ord_any),
    .trace_fire (trace_fire)
  );

  assign take_d     = commit_ok & (ord_any | trace_fire);
  assign next_cause = ord_any ? ord_code : CAUSE_W'(CZ_TRACE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_take  <= 1'b0;
      trap_cause <= CAUSE_W'(CZ_NONE);
    end else begin
      trap_take <= take_d;
      if (ret_strobe)  trap_cause <= CAUSE_W'(CZ_NONE);
      else if (take_d) trap_cause <= next_cause;
    end
  end

  a_r13_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> $past(commit && !ret_strobe));
  a_r7_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (trap_cause != CAUSE_W'(CZ_NONE) && trap_cause <= CAUSE_W'(CZ_TRACE)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_d && !ret_strobe) |=> $stable(trap_cause));
  a_r12_ret_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |=> (!trap_take && trap_cause == CAUSE_W'(CZ_NONE)));
endmodule

// File: tb/test_trace_trap_unit.sv
module test_trace_trap_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ret_strobe = 1'b0, ret_trace_en = 1'b0, commit = 1'b0;
  logic       irq_pending = 1'b0, req_dtype = 1'b0, req_ovf = 1'b0, req_mdata = 1'b0;
  logic       trap_take;
  logic [2:0] trap_cause;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side model of the requirements
  logic [3:0] m_pend = '0;
  logic       m_armed = 1'b0, m_due = 1'b0;
  logic [2:0] m_cause = '0;

  always #10 clk = ~clk;   // 50 MHz

  trace_trap_unit i_trace_trap_unit (
    .clk, .rst_n, .ret_strobe, .ret_trace_en, .commit,
    .irq_pending, .req_dtype, .req_ovf, .req_mdata,
    .trap_take, .trap_cause
  );

  task automatic check(input string req, input logic tk, input logic [2:0] cz);
    n_cmp++;
    if (trap_take !== tk || trap_cause !== cz) begin
      n_bad++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               req, trap_take, trap_cause, tk, cz);
    end
  endtask

  task automatic drive_req(input logic [3:0] r);
    irq_pending = r[0]; req_dtype = r[1]; req_ovf = r[2]; req_mdata = r[3];
  endtask

  task automatic do_ret(input logic en);
    @(negedge clk);
    ret_strobe = 1'b1; ret_trace_en = en;
    @(negedge clk);
    ret_strobe = 1'b0; ret_trace_en = 1'b0;
    m_armed = en; m_due = 1'b0; m_cause = 3'd0;
    check("R10", 1'b0, 3'd0);
  endtask

  // one commit; model the expected trap and check one cycle later (R13)
  task automatic do_commit(input logic [3:0] r, input string req);
    logic [3:0] mg;
    logic       tk;
    @(negedge clk);
    commit = 1'b1; drive_req(r);
    @(negedge clk);
    commit = 1'b0; drive_req(4'b0);
    mg = r | m_pend;
    tk = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!tk && mg[i]) begin
        tk = 1'b1; m_cause = 3'(i + 1);
        m_pend = mg & ~(4'b1 << i);
        m_armed = 1'b0; m_due = 1'b0;
      end
    end
    if (!tk) begin
      m_pend = '0;
      if (m_due) begin
        tk = 1'b1; m_cause = 3'd5; m_due = 1'b0;
      end else begin
        m_due = m_armed; m_armed = 1'b0;
      end
    end
    check(req, tk, m_cause);
  endtask

  task automatic drain;
    do_ret(1'b0);
    while (m_pend != '0) do_commit(4'b0, "R8");
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: take=%0b cause=%0d expected completion", trap_take, trap_cause);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 3'd0);

    // R2: trace off after return, clean commits never trap
    do_ret(1'b0);
    do_commit(4'b0, "R2");
    do_commit(4'b0, "R2");

    // R3 / R4: basic single step, then pulse ends (R13)
    do_ret(1'b1);
    do_commit(4'b0, "R3");
    do_commit(4'b0, "R4");
    @(negedge clk);
    check("R13", 1'b0, 3'd5);
    repeat (3) @(negedge clk);
    check("R10", 1'b0, 3'd5);

    // R11: requests without commit are ignored
    do_ret(1'b0);
    @(negedge clk); drive_req(4'hF);
    @(negedge clk); drive_req(4'h0);
    check("R11", 1'b0, 3'd0);
    do_commit(4'b0, "R11");

    // R12: return and commit in the same cycle
    @(negedge clk);
    ret_strobe = 1'b1; ret_trace_en = 1'b1; commit = 1'b1; drive_req(4'hF);
    @(negedge clk);
    ret_strobe = 1'b0; ret_trace_en = 1'b0; commit = 1'b0; drive_req(4'h0);
    m_armed = 1'b1; m_due = 1'b0; m_cause = 3'd0;
    check("R12", 1'b0, 3'd0);
    do_commit(4'b0, "R12");
    do_commit(4'b0, "R12");

    // R6: memory-data fault alone cancels trace
    drain;
    do_ret(1'b1);
    do_commit(4'b1000, "R6");
    do_commit(4'b0, "R6");

    // R5 / R7 / R8: every combination at the returned-to commit
    for (int r = 0; r < 16; r++) begin
      drain;
      do_ret(1'b1);
      do_commit(4'(r), "R5");
      do_commit(4'b0, "R8");
      do_commit(4'b0, "R7");
    end

    // R9 / R8: every combination at the commit where trace is due
    for (int r = 0; r < 16; r++) begin
      drain;
      do_ret(1'b1);
      do_commit(4'b0, "R3");
      do_commit(4'(r), "R9");
      do_commit(4'b0, "R8");
      do_commit(4'b0, "R9");
    end

    // R8: new request arriving while causes are pending
    drain;
    do_commit(4'b1110, "R8");
    do_commit(4'b0001, "R8");
    do_commit(4'b0000, "R8");
    do_commit(4'b0000, "R8");
    do_commit(4'b0000, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule